// File: doc/BRIEF.md
# Multi-channel down-counting timer bank

A register-mapped block holding eight independent 32-bit counters that count down. Each channel owns two word slots on a small register bus. One slot holds a control byte with an enable bit and a two-bit mode field. The other slot holds the count. A shared `tick_i` strobe is the timer clock: on every cycle where it is high, each enabled channel steps down by one.

Software programs a channel in three steps. It clears the control byte, writes the count, then writes the enable bit together with the mode. Three modes are available. One-shot fires once and stops. Periodic reloads itself and keeps running. Free-running wraps through the full 32-bit range and never interrupts, so software reads it inverted to get a rising time base.

Every count write also loads a per-channel reload register. Each channel has a sticky interrupt output. Any write to that channel's control slot clears it.

Top module: `timer_bank`

## Requirements
- R1: Channel t has its control slot at byte offset 8*t and its count slot at 8*t+4, selected by `addr_i[5:3]` and `addr_i[2]`. Offsets of 0x40 and above read as zero, and writes to them change no channel.
- R2: The control read value has the enable bit at bit 0 and the mode at bits 5:4, with every other bit zero. Only byte lane 0 (`be_i[0]`) updates the control fields.
- R3: A count write loads both the counter and the reload register with the same value. Byte lanes with `be_i` low keep the matching byte of the previous reload value. A count read returns the live counter value.
- R4: `rdata_o` presents the read data in the cycle after a read request and holds its value while no read is requested.
- R5: An enabled channel decrements by one on each cycle with `tick_i` high. A disabled channel holds its count.
- R6: Mode 0 (and the spare code 3) runs free. The counter wraps from 0 to 0xFFFFFFFF and never sets the interrupt.
- R7: Mode 1 is one-shot. The tick that takes the count from 1 to 0 sets the interrupt, clears the enable bit and leaves the mode unchanged. The count then holds at 0. A channel enabled at count 0 expires on its first tick.
- R8: Mode 2 is periodic. A tick at count 1 (or 0) sets the interrupt and loads the reload value, so the period is equal to the reload value in ticks.
- R9: Each channel's interrupt is sticky. Any write to that channel's control slot clears it, whatever the byte enables. Other channels' interrupts are not affected.
- R10: In a cycle where a channel's control or count slot is written, that channel does not decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and counter clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timer clock strobe, one decrement per high cycle |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 8 | Byte address |
| be_i | input | 4 | Byte enables for writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | 8 | Sticky interrupt per channel |

## Verification
The bench pushes a one-shot channel through the last tick and beyond. A design that fails to drop the enable bit would keep counting past zero or fire again. A periodic channel is followed across two expiries: reloading off by one changes the count seen after the first expiry, and a missing reload leaves the channel stuck at zero.

A free-running channel is wrapped through zero. This catches a design that saturates or raises an interrupt there. Further cases cover a partial-byte count write, which a design that overwrites the whole word would corrupt, and a control write with byte lane 0 off, which must clear the interrupt and leave the mode untouched. Writes that land in the same cycle as a tick must not also decrement; a design that lets them would come out one count short. The last cases are an unmapped read and an unmapped write, which must not alias onto channel 0.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
  typedef enum logic [1:0] {
    MODE_FREE  = 2'd0,
    MODE_ONCE  = 2'd1,
    MODE_CYCLE = 2'd2,
    MODE_SPARE = 2'd3
  } tmr_mode_e;

  localparam int unsigned MODE_LSB = 4;
  localparam int unsigned SLOT_BYTES = 8;
endpackage

// File: rtl/timer_bank_decode.sv
module timer_bank_decode #(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned CH_W  = $clog2(N_CH)
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              mapped_o,
  output logic [CH_W-1:0]   ch_o,
  output logic              is_cnt_o,
  output logic [N_CH-1:0]   ctrl_we_o,
  output logic [N_CH-1:0]   cnt_we_o
);
  localparam int unsigned MAP_BYTES = N_CH * timer_bank_pkg::SLOT_BYTES;

  assign mapped_o = ({1'b0, addr_i} < (ADDR_W+1)'(MAP_BYTES));
  assign ch_o     = addr_i[CH_W+2:3];
  assign is_cnt_o = addr_i[2];

  for (genvar i = 0; i < N_CH; i++) begin : g_we
    logic hit;
    assign hit          = req_i && we_i && mapped_o && (ch_o == CH_W'(i));
    assign ctrl_we_o[i] = hit && !is_cnt_o;
    assign cnt_we_o[i]  = hit && is_cnt_o;
  end
endmodule

// File: rtl/timer_bank_chan.sv
module timer_bank_chan
  import timer_bank_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  localparam int unsigned NB   = CNT_W / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ctrl_we_i,
  input  logic             cnt_we_i,
  input  logic [NB-1:0]    be_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic             en_o,
  output tmr_mode_e        mode_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, rld_q, merged;
  logic             en_q, irq_q;
  tmr_mode_e        mode_q;
  logic             last;

  always_comb begin
    merged = rld_q;
    for (int b = 0; b < NB; b++) begin
      if (be_i[b]) merged[b*8 +: 8] = wdata_i[b*8 +: 8];
    end
  end

  assign last = (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      en_q   <= 1'b0;
      mode_q <= MODE_FREE;
      irq_q  <= 1'b0;
    end else if (ctrl_we_i) begin
      irq_q <= 1'b0;
      if (be_i[0]) begin
        en_q   <= wdata_i[0];
        mode_q <= tmr_mode_e'(wdata_i[MODE_LSB +: 2]);
      end
    end else if (cnt_we_i) begin
      cnt_q <= merged;
      rld_q <= merged;
    end else if (en_q && tick_i) begin
      unique case (mode_q)
        MODE_ONCE: begin
          if (last) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
            irq_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        MODE_CYCLE: begin
          if (last) begin
            cnt_q <= rld_q;
            irq_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: cnt_q <= cnt_q - CNT_W'(1);
      endcase
    end
  end

  assign en_o   = en_q;
  assign mode_o = mode_q;
  assign cnt_o  = cnt_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/timer_bank_rdmux.sv
module timer_bank_rdmux
  import timer_bank_pkg::*;
#(
  parameter int unsigned N_CH  = 8,
  parameter int unsigned CNT_W = 32,
  localparam int unsigned CH_W = $clog2(N_CH)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       rd_i,
  input  logic                       mapped_i,
  input  logic [CH_W-1:0]            ch_i,
  input  logic                       is_cnt_i,
  input  logic [N_CH-1:0]            en_i,
  input  logic [N_CH-1:0][1:0]       mode_i,
  input  logic [N_CH-1:0][CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0]           rdata_o
);
  logic [CNT_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (mapped_i) begin
      if (is_cnt_i) sel = cnt_i[ch_i];
      else begin
        sel[0]               = en_i[ch_i];
        sel[MODE_LSB +: 2]   = mode_i[ch_i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= sel;
  end
endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import timer_bank_pkg::*;
#(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned NB    = CNT_W / 8,
  localparam int unsigned CH_W  = $clog2(N_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NB-1:0]     be_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic [N_CH-1:0]   irq_o
);
  logic                       mapped, is_cnt;
  logic [CH_W-1:0]            ch;
  logic [N_CH-1:0]            ctrl_we, cnt_we, en;
  logic [N_CH-1:0][1:0]       mode;
  logic [N_CH-1:0][CNT_W-1:0] cnt;

  timer_bank_decode #(.N_CH(N_CH), .ADDR_W(ADDR_W)) i_decode (
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .mapped_o  (mapped),
    .ch_o      (ch),
    .is_cnt_o  (is_cnt),
    .ctrl_we_o (ctrl_we),
    .cnt_we_o  (cnt_we)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    tmr_mode_e m;
    timer_bank_chan #(.CNT_W(CNT_W)) i_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .ctrl_we_i (ctrl_we[i]),
      .cnt_we_i  (cnt_we[i]),
      .be_i      (be_i),
      .wdata_i   (wdata_i),
      .en_o      (en[i]),
      .mode_o    (m),
      .cnt_o     (cnt[i]),
      .irq_o     (irq_o[i])
    );
    assign mode[i] = m;
  end

  timer_bank_rdmux #(.N_CH(N_CH), .CNT_W(CNT_W)) i_rdmux (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (req_i && !we_i),
    .mapped_i (mapped),
    .ch_i     (ch),
    .is_cnt_i (is_cnt),
    .en_i     (en),
    .mode_i   (mode),
    .cnt_i    (cnt),
    .rdata_o  (rdata_o)
  );
endmodule

// File: rtl/timer_bank_chk.sv
module timer_bank_chk #(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned NB    = CNT_W / 8,
  localparam int unsigned CH_W  = $clog2(N_CH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NB-1:0]     be_i,
  input logic [CNT_W-1:0]  wdata_i,
  input logic [CNT_W-1:0]  rdata_o,
  input logic [N_CH-1:0]   irq_o
);
  localparam int unsigned TOP = N_CH * 8;
  logic off_map, rd, ctrl_rd;
  assign off_map = (int'(addr_i) >= TOP);
  assign rd      = req_i && !we_i;
  assign ctrl_rd = rd && !off_map && !addr_i[2];

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && off_map) |=> (rdata_o == '0)); // R1
  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rd |=> (rdata_o[CNT_W-1:6] == '0 && rdata_o[3:1] == '0)); // R2
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o)); // R4

  for (genvar i = 0; i < N_CH; i++) begin : g_irq
    logic cw;
    assign cw = req_i && we_i && !off_map && !addr_i[2] && (addr_i[CH_W+2:3] == CH_W'(i));
    AST_IRQ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cw |=> !irq_o[i]); // R9
    AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o[i] && !cw) |=> irq_o[i]); // R9
    AST_IRQ_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o[i]) |-> $past(tick_i)); // R7 R8
  end
endmodule

bind timer_bank timer_bank_chk #(.N_CH(N_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .be_i    (be_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o)
);

// File: tb/test_timer_bank.sv
module test_timer_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [3:0]  be_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [7:0]  irq_o;
  int checks = 0;
  int fails = 0;

  timer_bank i_timer_bank (.*);

  always #5 clk_i = ~clk_i;

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    req_i = 1; we_i = 1; addr_i = a; be_i = be; wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    req_i = 0; we_i = 0; be_i = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    req_i = 1; we_i = 0; addr_i = a;
    @(posedge clk_i); @(negedge clk_i);
    req_i = 0;
    d = rdata_o;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick_i = 1;
      @(posedge clk_i); @(negedge clk_i);
      tick_i = 0;
    end
  endtask

  task automatic program_ch(input int t, input logic [31:0] c, input logic [7:0] ctrl);
    wr(8'(8*t), 4'h1, 32'h0);
    wr(8'(8*t+4), 4'hF, c);
    wr(8'(8*t), 4'h1, {24'h0, ctrl});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R9 reset irq", {24'h0, irq_o}, 32'h0);
    rd(8'h18, d); chk("R2 reset ctrl", d, 32'h0);
    rd(8'h1C, d); chk("R3 reset count", d, 32'h0);
  endtask

  task automatic t_oneshot;
    logic [31:0] d;
    program_ch(1, 32'd5, 8'h11);
    ticks(4);
    chk("R7 no irq before zero", {24'h0, irq_o}, 32'h0);
    rd(8'h0C, d); chk("R5 count after 4 ticks", d, 32'd1);
    ticks(1);
    chk("R7 irq at zero", {24'h0, irq_o}, 32'h02);
    rd(8'h08, d); chk("R7 enable cleared mode kept", d, 32'h10);
    ticks(3);
    rd(8'h0C, d); chk("R7 holds at zero", d, 32'd0);
    wr(8'h08, 4'h1, 32'h0);
    chk("R9 ctrl write clears irq", {24'h0, irq_o}, 32'h0);
  endtask

  task automatic t_oneshot_zero;
    logic [31:0] d;
    program_ch(7, 32'd0, 8'h11);
    ticks(1);
    chk("R7 zero start fires", {24'h0, irq_o}, 32'h80);
    rd(8'h38, d); chk("R7 zero start disables", d, 32'h10);
    wr(8'h38, 4'hF, 32'h0);
  endtask

  task automatic t_periodic;
    logic [31:0] d;
    program_ch(2, 32'd3, 8'h21);
    ticks(3);
    chk("R8 irq on expiry", {24'h0, irq_o}, 32'h04);
    rd(8'h14, d); chk("R8 reloaded", d, 32'd3);
    wr(8'h10, 4'hE, 32'h0);
    chk("R9 lane0-off write clears irq", {24'h0, irq_o}, 32'h0);
    rd(8'h10, d); chk("R2 lane0-off keeps ctrl", d, 32'h21);
    ticks(2);
    rd(8'h14, d); chk("R8 running after reload", d, 32'd1);
    chk("R8 no early irq", {24'h0, irq_o}, 32'h0);
    ticks(1);
    chk("R8 second expiry", {24'h0, irq_o}, 32'h04);
    wr(8'h10, 4'h1, 32'h0);
  endtask

  task automatic t_free;
    logic [31:0] d;
    program_ch(4, 32'd2, 8'h01);
    ticks(3);
    rd(8'h24, d); chk("R6 wraps through zero", d, 32'hFFFF_FFFF);
    chk("R6 no irq", {24'h0, irq_o}, 32'h0);
    program_ch(4, 32'd0, 8'h31);
    ticks(1);
    rd(8'h24, d); chk("R6 spare mode runs free", d, 32'hFFFF_FFFF);
    chk("R6 spare mode no irq", {24'h0, irq_o}, 32'h0);
    wr(8'h20, 4'h1, 32'h0);
  endtask

  task automatic t_bytes;
    logic [31:0] d;
    wr(8'h2C, 4'hF, 32'h1122_3344);
    wr(8'h2C, 4'h2, 32'h0000_AA00);
    rd(8'h2C, d); chk("R3 byte merge from reload", d, 32'h1122_AA44);
  endtask

  task automatic t_disabled;
    logic [31:0] d;
    wr(8'h34, 4'hF, 32'd7);
    ticks(5);
    rd(8'h34, d); chk("R5 disabled holds", d, 32'd7);
  endtask

  task automatic t_write_vs_tick;
    logic [31:0] d;
    program_ch(3, 32'd10, 8'h01);
    tick_i = 1;
    wr(8'h1C, 4'hF, 32'd20);
    tick_i = 0;
    rd(8'h1C, d); chk("R10 count write no decrement", d, 32'd20);
    ticks(1);
    rd(8'h1C, d); chk("R5 decrement after write", d, 32'd19);
    tick_i = 1;
    wr(8'h18, 4'h1, 32'h01);
    tick_i = 0;
    rd(8'h1C, d); chk("R10 ctrl write no decrement", d, 32'd19);
    wr(8'h18, 4'h1, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd(8'h1C, d);
    rd(8'h40, d); chk("R1 unmapped read zero", d, 32'h0);
    wr(8'h44, 4'hF, 32'hDEAD_BEEF);
    wr(8'h40, 4'h1, 32'h01);
    rd(8'h04, d); chk("R1 unmapped write no alias count", d, 32'h0);
    rd(8'h00, d); chk("R1 unmapped write no alias ctrl", d, 32'h0);
    rd(8'hFC, d); chk("R1 high offset read zero", d, 32'h0);
    ticks(2);
    chk("R4 rdata holds without read", rdata_o, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_oneshot();
    t_oneshot_zero();
    t_periodic();
    t_free();
    t_bytes();
    t_disabled();
    t_write_vs_tick();
    t_unmapped();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule